// File: doc/BRIEF.md
# Low-Power Freeze Mode Controller

This block moves a chip core into and out of a static freeze state, where power is lowest, on request from an active-low external pin. While the core is frozen, its clock is stopped by a glitch-free gate and its inputs are held, so every register and memory keeps its contents. When the pin is released the clock restarts and the core carries on from the state it kept. The controller also drives the I/O output enables and the weak pull selection, and one enable for the PLL and charge pumps. The analog parts behind those enables are outside this block.

The pin first passes through a two-flop synchronizer and a debounce filter. In direct mode a filtered request starts entry at once. In qualified mode the request is shown to user logic, and entry waits for a grant. Exit never waits for a grant. The pin can also be freed from freeze duty entirely, and its synchronized level is always available as an ordinary input. The controller steps through five states, one after another: active, request pending, gating, frozen and ungating. Each state has its own status bit.

Top module: `freeze_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the outputs are:
  - `state_o` = 5'b00001
  - `freeze_req_o` = 0, `pin_level_o` = 1, `io_oe_o` = 1, `pll_en_o` = 1
  - `core_in_hold_o` = 0, `io_pu_o` = 0, `io_pd_o` = 0
- R2: `frz_pin_n` is sampled by two flops and then filtered. The filtered level takes a new value only after DEB_LEN consecutive synchronized samples that differ from it. A low pin first sampled at edge k raises `freeze_req_o` (while `cfg_pin_en`=1) right after edge k+DEB_LEN+1.
- R3: A low pulse on the pin that lasts fewer than DEB_LEN clock samples does not raise `freeze_req_o` and does not move the state out of active.
- R4: In direct mode (`cfg_qualified`=0), an active controller that sees `freeze_req_o` high enters the gating state on the next edge.
- R5: In qualified mode (`cfg_qualified`=1), the request first takes the controller to request-pending.
  - It stays there while `user_grant` is low.
  - It moves to gating on the edge where `user_grant` is high.
  - It returns to active if the request drops first.
- R6: Gating lasts SEQ_CYC cycles and then leads to frozen. Ungating lasts SEQ_CYC cycles and then leads to active. Frozen is reached only from gating.
- R7: The gated clock `core_clk_o` gives a high pulse in a cycle exactly when the state held during the previous cycle was not frozen. It gives no pulse while frozen.
- R8: In the gating, frozen and ungating states, `core_in_hold_o`=1 and `io_oe_o`=0. `pll_en_o` is low only in the frozen state.
- R9: While the inputs are held, the pull code `cfg_pull` selects the weak pull:
  - 2'b10 asserts `io_pu_o`.
  - 2'b01 asserts `io_pd_o`.
  - 2'b00 and 2'b11 leave the pad tristated, with neither pull asserted.
  - Outside the hold states neither pull is asserted.
- R10: In both modes, a frozen controller whose request has dropped enters ungating on the next edge. No grant is needed for this.
- R11: With `cfg_pin_en`=0, the pin never raises `freeze_req_o` or leaves the active state. `pin_level_o` shows the pin as sampled one edge before the latest one.
- R12: `state_o` is one-hot: bit 0 is active, bit 1 is request-pending, bit 2 is gating, bit 3 is frozen and bit 4 is ungating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frz_pin_n | input | 1 | External freeze request pin, active low |
| cfg_pin_en | input | 1 | 1: pin drives freeze requests; 0: ordinary input only |
| cfg_qualified | input | 1 | 1: entry waits for user grant; 0: direct entry |
| cfg_pull | input | 2 | Pad pull while held: 10 up, 01 down, 00/11 none |
| user_grant | input | 1 | User logic permits entry (qualified mode) |
| pin_level_o | output | 1 | Synchronized pin level |
| freeze_req_o | output | 1 | Filtered freeze request seen by user logic |
| core_clk_o | output | 1 | Gated core clock |
| core_in_hold_o | output | 1 | Hold core inputs |
| io_oe_o | output | 1 | Output enable to the pads |
| io_pu_o | output | 1 | Weak pull-up enable |
| io_pd_o | output | 1 | Weak pull-down enable |
| pll_en_o | output | 1 | PLL and charge-pump enable |
| state_o | output | 5 | One-hot status of the sequencer |

## Verification
Every registered result is due at a fixed number of edges after its stimulus:
- `pin_level_o` follows the pin two sampling edges later.
- `freeze_req_o` rises DEB_LEN+1 edges after the edge that first samples the pin low.
- Each state step of the sequence takes one edge.
- Gating and ungating each last SEQ_CYC edges.
- The hold, enable and pull outputs follow the state with no further delay.
- `core_clk_o` lags the state by one cycle, because its latch only opens in the low phase.

The bench steps a behavioural model at every rising edge. It compares every output 2 ns later, in the high phase, so the gated clock shows the enable latched in the previous low phase. Directed checks at falling edges confirm the frozen, pending and filtered cases.

// File: rtl/freeze_pkg.sv
`timescale 1ns/1ps
// Shared types for the freeze controller: sequencer states and pull codes.
package freeze_pkg;
    typedef enum logic [2:0] {
        FZ_ACTIVE = 3'd0,
        FZ_REQ    = 3'd1,
        FZ_GATE   = 3'd2,
        FZ_FROZEN = 3'd3,
        FZ_UNGATE = 3'd4
    } fz_state_e;

    localparam int unsigned NUM_STATES = 5;
    localparam logic [1:0] PULL_DOWN = 2'b01;
    localparam logic [1:0] PULL_UP   = 2'b10;
endpackage

// File: rtl/freeze_pin_filter.sv
`timescale 1ns/1ps
// Freeze pin conditioning.
// Synchronizes the asynchronous active-low pin with two flops. A run counter
// then lets the filtered level change only after DEB_LEN consecutive
// synchronized samples that differ from it.
// Assumes DEB_LEN >= 2. Reset value is "released" (high).
module freeze_pin_filter #(
    parameter int unsigned DEB_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic sync_o,
    output logic filt_o
);
    localparam int unsigned CW = (DEB_LEN > 2) ? $clog2(DEB_LEN) : 1;

    logic          sync1, sync2, filt;
    logic [CW-1:0] run;

    // Two-flop synchronizer followed by the debounce run counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            filt  <= 1'b1;
            run   <= '0;
        end else begin
            sync1 <= pin_n;
            sync2 <= sync1;
            if (sync2 == filt) begin
                run <= '0;
            end else if (run == CW'(DEB_LEN - 1)) begin
                filt <= sync2;
                run  <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    assign sync_o = sync2;
    assign filt_o = filt;

    AST_FILT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> ($past(sync2) != $past(filt))); // R2
endmodule

// File: rtl/freeze_seq_fsm.sv
`timescale 1ns/1ps
// Freeze entry/exit sequencer.
// Walks active -> (request pending) -> gating -> frozen -> ungating -> active.
// Direct mode skips the pending state. Exit follows a dropped request at
// once in both modes. Gating and ungating each last SEQ_CYC cycles.
// Assumes SEQ_CYC >= 2 and that req is already synchronized.
module freeze_seq_fsm
    import freeze_pkg::*;
#(
    parameter int unsigned SEQ_CYC = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  logic      qualified,
    input  logic      grant,
    output fz_state_e state_o
);
    localparam int unsigned SW = (SEQ_CYC > 2) ? $clog2(SEQ_CYC) : 1;

    fz_state_e     state, state_nx;
    logic [SW-1:0] seq_cnt;
    logic          seq_last;

    assign seq_last = (seq_cnt == SW'(SEQ_CYC - 1));

    // Next-state selection for the freeze sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            FZ_ACTIVE: if (req) state_nx = qualified ? FZ_REQ : FZ_GATE;
            FZ_REQ: begin
                if (!req)       state_nx = FZ_ACTIVE;
                else if (grant) state_nx = FZ_GATE;
            end
            FZ_GATE:   if (seq_last) state_nx = FZ_FROZEN;
            FZ_FROZEN: if (!req) state_nx = FZ_UNGATE;
            FZ_UNGATE: if (seq_last) state_nx = FZ_ACTIVE;
            default:   state_nx = FZ_ACTIVE;
        endcase
    end

    // State register and dwell counter for the timed gating/ungating states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FZ_ACTIVE;
            seq_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state) seq_cnt <= '0;
            else                   seq_cnt <= seq_cnt + 1'b1;
        end
    end

    assign state_o = state;

    AST_DIRECT_SKIPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FZ_ACTIVE && req && !qualified) |=> (state == FZ_GATE)); // R4
    AST_QUAL_WAITS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FZ_REQ && req && !grant) |=> (state == FZ_REQ)); // R5
    AST_EXIT_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FZ_FROZEN && !req) |=> (state == FZ_UNGATE)); // R10
    AST_FROZEN_FROM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FZ_FROZEN) |-> ($past(state) == FZ_GATE || $past(state) == FZ_FROZEN)); // R6
endmodule

// File: rtl/freeze_clk_gate.sv
`timescale 1ns/1ps
// Glitch-free clock gate.
// A level latch, transparent while clk is low, captures the enable. The
// gated clock can therefore only switch off or on during the low phase.
module freeze_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // Capture the enable only while the clock is low.
    always_latch begin
        if (!clk) en_lat = en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/freeze_ctrl.sv
`timescale 1ns/1ps
// Low-power freeze mode controller (top).
// Joins pin conditioning, the entry/exit sequencer and the core clock gate.
// It decodes the hold, output-enable, pull and PLL enables from the state.
// Assumes clk is free running and the core is clocked only from core_clk_o.
module freeze_ctrl
    import freeze_pkg::*;
#(
    parameter int unsigned DEB_LEN = 4,
    parameter int unsigned SEQ_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frz_pin_n,
    input  logic       cfg_pin_en,
    input  logic       cfg_qualified,
    input  logic [1:0] cfg_pull,
    input  logic       user_grant,
    output logic       pin_level_o,
    output logic       freeze_req_o,
    output logic       core_clk_o,
    output logic       core_in_hold_o,
    output logic       io_oe_o,
    output logic       io_pu_o,
    output logic       io_pd_o,
    output logic       pll_en_o,
    output logic [NUM_STATES-1:0] state_o
);
    logic      filt_n;
    logic      hold;
    fz_state_e state;

    freeze_pin_filter #(.DEB_LEN(DEB_LEN)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (frz_pin_n),
        .sync_o (pin_level_o),
        .filt_o (filt_n)
    );

    assign freeze_req_o = cfg_pin_en & ~filt_n;

    freeze_seq_fsm #(.SEQ_CYC(SEQ_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (freeze_req_o),
        .qualified (cfg_qualified),
        .grant     (user_grant),
        .state_o   (state)
    );

    freeze_clk_gate u_cg (
        .clk  (clk),
        .en   (state != FZ_FROZEN),
        .gclk (core_clk_o)
    );

    // Decode the I/O and analog enables from the sequencer state.
    always_comb begin
        hold           = (state == FZ_GATE) || (state == FZ_FROZEN) || (state == FZ_UNGATE);
        core_in_hold_o = hold;
        io_oe_o        = ~hold;
        io_pu_o        = hold && (cfg_pull == PULL_UP);
        io_pd_o        = hold && (cfg_pull == PULL_DOWN);
        pll_en_o       = (state != FZ_FROZEN);
    end

    // One status bit per state.
    for (genvar i = 0; i < NUM_STATES; i++) begin : g_status
        assign state_o[i] = (state == fz_state_e'(i));
    end

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_o)); // R12
    AST_PLL_OFF_IS_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en_o |-> (core_in_hold_o && !io_oe_o)); // R8
    AST_PULLS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_pu_o && io_pd_o)); // R9
    AST_NO_REQ_WHEN_FREED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pin_en && state_o[0]) |=> state_o[0]); // R11
endmodule

// File: tb/freeze_ctrl_test.sv
`timescale 1ns/1ps
module freeze_ctrl_test;
    localparam int DEB = 4;
    localparam int SEQ = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frz_pin_n = 1'b1, cfg_pin_en = 1'b1, cfg_qualified = 1'b0, user_grant = 1'b0;
    logic [1:0] cfg_pull = 2'b00;
    logic pin_level_o, freeze_req_o, core_clk_o, core_in_hold_o, io_oe_o, io_pu_o, io_pd_o, pll_en_o;
    logic [4:0] state_o;

    freeze_ctrl #(.DEB_LEN(DEB), .SEQ_CYC(SEQ)) uut (.*);

    always #5 clk = ~clk;

    int checks = 0, errors = 0, gpulses = 0;
    bit chk_en = 0, done = 0, saw_req = 0;

    always @(posedge core_clk_o) gpulses++;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: history of pin samples, run-length filter, sequence.
    int m_state = 0, m_cnt = 0, prev_state = 0;
    bit m_filt = 1;
    bit hist[$];

    always @(posedge clk) begin
        bit req, all_diff;
        int nx;
        if (!rst_n) begin
            hist = {};
            for (int i = 0; i < DEB + 2; i++) hist.push_back(1'b1);
            m_filt = 1; m_state = 0; m_cnt = 0; prev_state = 0;
        end else begin
            prev_state = m_state;
            req = cfg_pin_en && !m_filt;
            nx = m_state;
            case (m_state)
                0: if (req) nx = cfg_qualified ? 1 : 2;
                1: if (!req) nx = 0; else if (user_grant) nx = 2;
                2: if (m_cnt == SEQ - 1) nx = 3;
                3: if (!req) nx = 4;
                4: if (m_cnt == SEQ - 1) nx = 0;
                default: nx = 0;
            endcase
            m_cnt = (nx != m_state) ? 0 : m_cnt + 1;
            m_state = nx;
            hist.push_back(frz_pin_n);
            if (hist.size() > DEB + 4) void'(hist.pop_front());
            all_diff = 1;
            for (int j = 2; j <= DEB + 1; j++)
                if (hist[hist.size() - 1 - j] == m_filt) all_diff = 0;
            if (all_diff) m_filt = !m_filt;
        end
        #2;
        if (chk_en) begin
            bit hold;
            hold = (m_state >= 2);
            chk("R12/R4/R5/R6/R10 state", state_o, 1 << m_state);
            chk("R2 freeze_req", freeze_req_o, cfg_pin_en && !m_filt);
            chk("R11 pin_level", pin_level_o, hist[hist.size() - 2]);
            chk("R8 in_hold", core_in_hold_o, hold);
            chk("R8 io_oe", io_oe_o, !hold);
            chk("R8 pll_en", pll_en_o, m_state != 3);
            chk("R9 pull_up", io_pu_o, hold && cfg_pull == 2'b10);
            chk("R9 pull_down", io_pd_o, hold && cfg_pull == 2'b01);
            chk("R7 core_clk", core_clk_o, prev_state != 3);
            if (freeze_req_o) saw_req = 1;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int g0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        chk_en = 1;
        // R1 reset state
        chk("R1 state", state_o, 1); chk("R1 req", freeze_req_o, 0);
        chk("R1 oe", io_oe_o, 1); chk("R1 pll", pll_en_o, 1);
        chk("R1 hold", core_in_hold_o, 0); chk("R1 pin_level", pin_level_o, 1);

        // Direct entry and exit (R4, R6, R7, R10), pull up while frozen
        cfg_pull = 2'b10;
        frz_pin_n = 1'b0;
        cyc(16);
        chk("R4/R6 direct frozen", state_o, 8);
        chk("R9 pull up frozen", io_pu_o, 1);
        g0 = gpulses; cyc(6);
        chk("R7 no clock while frozen", gpulses - g0, 0);
        cfg_pull = 2'b01; cyc(1);
        chk("R9 pull down frozen", io_pd_o, 1);
        cfg_pull = 2'b11; cyc(1);
        chk("R9 code 11 no pull", io_pu_o + io_pd_o, 0);
        frz_pin_n = 1'b1;
        cyc(14);
        chk("R10/R6 exit to active", state_o, 1);
        g0 = gpulses; cyc(4);
        chk("R7 clock resumed", gpulses - g0, 4);

        // Short glitch ignored (R3)
        saw_req = 0;
        frz_pin_n = 1'b0; cyc(DEB - 2); frz_pin_n = 1'b1;
        cyc(15);
        chk("R3 glitch no request", saw_req, 0);
        chk("R3 glitch still active", state_o, 1);

        // Qualified mode: wait for grant (R5), exit without grant (R10)
        cfg_qualified = 1'b1; cfg_pull = 2'b00;
        frz_pin_n = 1'b0; cyc(12);
        chk("R5 pending", state_o, 2);
        cyc(6);
        chk("R5 still pending without grant", state_o, 2);
        user_grant = 1'b1; cyc(1); user_grant = 1'b0;
        cyc(8);
        chk("R5 granted to frozen", state_o, 8);
        chk("R9 code 00 tristate", io_pu_o + io_pd_o, 0);
        frz_pin_n = 1'b1; cyc(14);
        chk("R10 qualified exit", state_o, 1);

        // Qualified request withdrawn (R5)
        frz_pin_n = 1'b0; cyc(12);
        chk("R5 pending again", state_o, 2);
        frz_pin_n = 1'b1; cyc(10);
        chk("R5 withdrawn to active", state_o, 1);

        // Pin freed from freeze duty (R11)
        cfg_pin_en = 1'b0; cfg_qualified = 1'b0; saw_req = 0;
        frz_pin_n = 1'b0; cyc(3);
        chk("R11 pin level low", pin_level_o, 0);
        cyc(15);
        chk("R11 no request", saw_req, 0);
        chk("R11 stays active", state_o, 1);
        frz_pin_n = 1'b1; cyc(3);
        chk("R11 pin level high", pin_level_o, 1);

        // Direct again with grant idle and a long freeze
        cfg_pin_en = 1'b1;
        frz_pin_n = 1'b0; cyc(40);
        chk("R4 direct re-entry", state_o, 8);
        frz_pin_n = 1'b1; cyc(14);
        chk("R10 final exit", state_o, 1);

        finish_run();
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule